// File: doc/BRIEF.md
# String Word Load/Store Sequencer

This block moves a byte-counted string between memory and a register file of `NREG` 32-bit registers. A one-cycle start pulse supplies a first register index, a byte address, a byte count and three mode bits: direction (load or store), byte ordering (big-endian or byte-reversed) and multiple-word mode. The sequencer then issues one memory request at a time on a simple request/acknowledge port. While at least four bytes are left it moves whole 32-bit words. Any remainder of one to three bytes is moved with single-byte requests.

On a load, whole words are written to the register file when their acknowledge arrives. Trailing bytes are gathered into one register, which is written after the last byte returns. On a store, whole words and trailing bytes are taken from a combinational register-file read port. In multiple-word mode the byte count input is ignored. Every register from the start index up to the highest one is transferred, one word each. A one-cycle done pulse marks the end of each sequence.

Top module: `strx_seq`

## Requirements
- R1: While four or more bytes remain, each request is a word request (`mem_word_o`=1); successive word addresses differ by 4 and four bytes are consumed per word.
- R2: After each whole word the register index advances by one, wrapping from NREG-1 (31) to 0.
- R3: With 1 to 3 bytes left, each byte uses its own byte request (`mem_word_o`=0), and the address rises by 1 per byte.
- R4: Big-endian load tail: the first trailing byte lands in bits 31:24 of the next register, the next in 23:16, then 15:8, and any bytes not filled read as zero.
- R5: Byte-reversed words are swapped in both directions: memory word bits 7:0 go to register bits 31:24, 15:8 to 23:16, 23:16 to 15:8 and 31:24 to 7:0. The memory word holds the byte at the lowest address in bits 31:24.
- R6: Byte-reversed load tail: the first trailing byte lands in bits 7:0, the next in 15:8, then 23:16; higher bytes are zero.
- R7: A store tail takes each byte from the last source register at the bit position a load in the same mode would fill, and presents it on `mem_wdata_o[7:0]`. A store never writes the register file.
- R8: In multiple-word mode the count input is ignored. Registers from the start index through NREG-1 move one word each at consecutive word addresses, with no wrap and no byte requests.
- R9: When no bytes are left after the whole words, no byte request and no tail register write occur. A count of zero completes with no request and no write.
- R10: A request holds its address, size, direction and write data stable until it is acknowledged; at most one request is outstanding.
- R11: A start pulse while busy is ignored. `done_o` is high for exactly one cycle, the cycle after the final acknowledge or register write (or after the start pulse for an empty sequence).
- R12: After reset no request, register write or done is asserted and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| store_i | input | 1 | 1 = store (registers to memory), 0 = load |
| rev_i | input | 1 | 1 = byte-reversed ordering, 0 = big-endian |
| multi_i | input | 1 | 1 = multiple-word mode (count ignored) |
| reg_idx_i | input | 5 | First register index |
| addr_i | input | 32 | First byte address |
| count_i | input | 8 | Byte count |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_word_o | output | 1 | 1 = 32-bit word request, 0 = single byte |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data (byte requests use bits 7:0) |
| mem_ack_i | input | 1 | Request acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge (byte in bits 7:0) |
| rf_raddr_o | output | 5 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. Requests must hold steady until acknowledged. Word requests are only made with four or more bytes left, and byte requests only with one to three left. In multiple-word mode the last word must coincide with the highest register index. Every done pulse must follow a completing event by exactly one cycle. The bench scenarios are the only place where data is checked against expected values: byte-lane placement in both orderings, the zero fill of a partial tail, the index wrap, the ignored count in multiple-word mode and the ignored start while busy. Those checks compare register and memory contents with values computed from the requirements.

// File: rtl/strx_pkg.sv
package strx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WORD   = 3'd1,
    ST_BYTE   = 3'd2,
    ST_TAILWR = 3'd3,
    ST_FIN    = 3'd4
  } strx_state_e;
endpackage

// File: rtl/strx_track.sv
// Address, remaining-count, register-index and tail-lane counters.
module strx_track #(
  parameter int AW   = 32,
  parameter int CW   = 8,
  parameter int NREG = 32,
  parameter int NB   = 4,
  localparam int IW  = $clog2(NREG),
  localparam int LW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          multi_in,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [IW-1:0] idx_in,
  input  logic          word_step,
  input  logic          byte_step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] rem_q,
  output logic [IW-1:0] idx_q,
  output logic [LW-1:0] lane_q
);
  localparam logic [IW-1:0] IDX_TOP = IW'(NREG - 1);

  logic [AW-1:0] addr_d;
  logic [CW-1:0] rem_d;
  logic [IW-1:0] idx_d;
  logic [LW-1:0] lane_d;
  logic          multi_q, multi_d;
  logic          upd_en;

  assign upd_en = load_en | word_step | byte_step;

  always_comb begin
    addr_d  = addr_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    lane_d  = lane_q;
    multi_d = multi_q;
    if (load_en) begin
      addr_d  = addr_in;
      rem_d   = cnt_in;
      idx_d   = idx_in;
      lane_d  = '0;
      multi_d = multi_in;
    end else if (word_step) begin
      addr_d = addr_q + AW'(NB);
      rem_d  = rem_q - CW'(NB);
      idx_d  = (idx_q == IDX_TOP) ? '0 : idx_q + 1'b1;
    end else if (byte_step) begin
      addr_d = addr_q + 1'b1;
      rem_d  = rem_q - 1'b1;
      lane_d = lane_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      lane_q  <= '0;
      multi_q <= 1'b0;
    end else if (upd_en) begin
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      lane_q  <= lane_d;
      multi_q <= multi_d;
    end
  end

  // R1: a whole word is only moved when at least a word of bytes is left
  p_word_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_step |-> (rem_q >= CW'(NB)));

  // R3: single-byte steps only happen inside the 1..NB-1 tail
  p_byte_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_step |-> (rem_q != '0 && rem_q < CW'(NB)));

  // R8: in multiple-word mode the top register carries the last word
  p_multi_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step && multi_q && idx_q == IDX_TOP) |-> (rem_q == CW'(NB)));
endmodule

// File: rtl/strx_lane.sv
// Byte lane placement: word swap and tail byte select/merge per ordering.
module strx_lane #(
  parameter int DW  = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic          rev,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] acc_q,
  output logic [DW-1:0] word_to_rf,
  output logic [DW-1:0] word_to_mem,
  output logic [7:0]    byte_to_mem,
  output logic [DW-1:0] acc_next
);
  logic [DW-1:0] swap_rd;
  logic [DW-1:0] swap_wr;
  logic [LW-1:0] pos;
  logic [DW-1:0] byte_ext;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swap_rd[b*8 +: 8] = mem_rdata[(NB-1-b)*8 +: 8];
    assign swap_wr[b*8 +: 8] = rf_rdata[(NB-1-b)*8 +: 8];
  end

  assign word_to_rf  = rev ? swap_rd : mem_rdata;
  assign word_to_mem = rev ? swap_wr : rf_rdata;

  // Byte position inside the register for the current tail byte.
  assign pos = rev ? lane : LW'(NB - 1) - lane;

  assign byte_to_mem = rf_rdata[{pos, 3'b000} +: 8];
  assign byte_ext    = {{(DW-8){1'b0}}, mem_rdata[7:0]};
  assign acc_next    = acc_q | (byte_ext << {pos, 3'b000});
endmodule

// File: rtl/strx_ctrl.sv
// Sequence control: idle, word steps, byte steps, tail write, finish.
module strx_ctrl
  import strx_pkg::*;
#(
  parameter int CW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          store_in,
  input  logic          rev_in,
  input  logic [CW-1:0] cnt_eff,
  input  logic [CW-1:0] rem_q,
  input  logic          mem_ack,
  output strx_state_e   state_q,
  output logic          store_q,
  output logic          rev_q,
  output logic          load_en,
  output logic          word_step,
  output logic          byte_step,
  output logic          busy,
  output logic          done
);
  strx_state_e state_d;
  logic        store_d, rev_d;

  always_comb begin
    state_d   = state_q;
    store_d   = store_q;
    rev_d     = rev_q;
    load_en   = 1'b0;
    word_step = 1'b0;
    byte_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          store_d = store_in;
          rev_d   = rev_in;
          if (cnt_eff >= CW'(NB))    state_d = ST_WORD;
          else if (cnt_eff != '0)    state_d = ST_BYTE;
          else                       state_d = ST_FIN;
        end
      end
      ST_WORD: begin
        if (mem_ack) begin
          word_step = 1'b1;
          if (rem_q >= CW'(2*NB))    state_d = ST_WORD;
          else if (rem_q == CW'(NB)) state_d = ST_FIN;
          else                       state_d = ST_BYTE;
        end
      end
      ST_BYTE: begin
        if (mem_ack) begin
          byte_step = 1'b1;
          if (rem_q == CW'(1)) state_d = store_q ? ST_FIN : ST_TAILWR;
        end
      end
      ST_TAILWR: state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
      rev_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        store_q <= store_d;
        rev_q   <= rev_d;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);

  // R11: a start seen while busy leaves the sequence running
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);
endmodule

// File: rtl/strx_seq.sv
module strx_seq
  import strx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 8,
  parameter int NREG = 32,
  localparam int DW  = 32,
  localparam int NB  = DW / 8,
  localparam int IW  = $clog2(NREG),
  localparam int LW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          store_i,
  input  logic          rev_i,
  input  logic          multi_i,
  input  logic [IW-1:0] reg_idx_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_word_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [IW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [IW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          busy_o,
  output logic          done_o
);
  strx_state_e   state_q;
  logic          store_q, rev_q;
  logic          load_en, word_step, byte_step;
  logic [CW-1:0] cnt_eff;
  logic [CW-1:0] rem_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q;
  logic [LW-1:0] lane_q;
  logic [DW-1:0] word_to_rf, word_to_mem, acc_next;
  logic [7:0]    byte_to_mem;
  logic [DW-1:0] acc_q, acc_d;
  logic          acc_en;

  // Multiple-word mode: one word per register up to the top index.
  assign cnt_eff = multi_i ? (CW'(NREG * NB) - CW'({reg_idx_i, 2'b00})) : count_i;

  strx_ctrl #(.CW(CW), .NB(NB)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .store_in  (store_i),
    .rev_in    (rev_i),
    .cnt_eff   (cnt_eff),
    .rem_q     (rem_q),
    .mem_ack   (mem_ack_i),
    .state_q   (state_q),
    .store_q   (store_q),
    .rev_q     (rev_q),
    .load_en   (load_en),
    .word_step (word_step),
    .byte_step (byte_step),
    .busy      (busy_o),
    .done      (done_o)
  );

  strx_track #(.AW(AW), .CW(CW), .NREG(NREG), .NB(NB)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .multi_in  (multi_i),
    .addr_in   (addr_i),
    .cnt_in    (cnt_eff),
    .idx_in    (reg_idx_i),
    .word_step (word_step),
    .byte_step (byte_step),
    .addr_q    (addr_q),
    .rem_q     (rem_q),
    .idx_q     (idx_q),
    .lane_q    (lane_q)
  );

  strx_lane #(.DW(DW)) u_lane (
    .rev         (rev_q),
    .lane        (lane_q),
    .mem_rdata   (mem_rdata_i),
    .rf_rdata    (rf_rdata_i),
    .acc_q       (acc_q),
    .word_to_rf  (word_to_rf),
    .word_to_mem (word_to_mem),
    .byte_to_mem (byte_to_mem),
    .acc_next    (acc_next)
  );

  // Tail accumulator for loads: cleared at start, merged per byte.
  always_comb begin
    acc_en = load_en | (byte_step & ~store_q);
    acc_d  = load_en ? '0 : acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_comb begin
    mem_req_o   = (state_q == ST_WORD) || (state_q == ST_BYTE);
    mem_word_o  = (state_q == ST_WORD);
    mem_we_o    = mem_req_o && store_q;
    mem_addr_o  = addr_q;
    mem_wdata_o = '0;
    if (mem_we_o) mem_wdata_o = mem_word_o ? word_to_mem : {{(DW-8){1'b0}}, byte_to_mem};
    rf_raddr_o  = idx_q;
    rf_waddr_o  = idx_q;
    rf_we_o     = ((state_q == ST_WORD) && mem_ack_i && !store_q) || (state_q == ST_TAILWR);
    rf_wdata_o  = (state_q == ST_TAILWR) ? acc_q : word_to_rf;
  end

  // R10: a pending request keeps every attribute until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_word_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R11: done follows an acknowledge, a register write or an accepted start
  p_done_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past((mem_req_o && mem_ack_i) || rf_we_o || (start_i && !busy_o)));

  // R7: a store never writes the register file
  p_store_no_rf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !rf_we_o);
endmodule

// File: tb/strx_seq_tb.sv
module strx_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, store_i = 1'b0, rev_i = 1'b0, multi_i = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic [31:0] addr_i = '0;
  logic [7:0]  count_i = '0;
  logic        mem_req_o, mem_we_o, mem_word_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [4:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, busy_o, done_o;

  logic [7:0]  mem [0:255];
  logic [31:0] rf  [0:31];
  int n_chk = 0, n_fail = 0;
  int n_word = 0, n_byte = 0, n_we = 0, n_done = 0;
  int stab_err = 0, gap_err = 0;
  int lat_cfg = 0, wait_cnt = 0;
  int cyc = 0, last_evt = 0;
  logic        p_req = 1'b0, p_ack = 1'b0;
  logic [31:0] p_addr = '0;

  always #4 clk = ~clk;  // 125 MHz

  strx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i), .rev_i(rev_i),
    .multi_i(multi_i), .reg_idx_i(reg_idx_i), .addr_i(addr_i), .count_i(count_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_word_o(mem_word_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .busy_o(busy_o), .done_o(done_o));

  assign rf_rdata_i = rf[rf_raddr_o];

  // Memory responder: lowest address is the most significant word byte.
  always @(posedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
    end else if (mem_req_o && rst_n) begin
      if (wait_cnt < lat_cfg) wait_cnt <= wait_cnt + 1;
      else begin
        wait_cnt  <= 0;
        mem_ack_i <= 1'b1;
        if (mem_word_o) begin
          n_word++;
          mem_rdata_i <= {mem[mem_addr_o[7:0]], mem[8'(mem_addr_o[7:0]+1)],
                          mem[8'(mem_addr_o[7:0]+2)], mem[8'(mem_addr_o[7:0]+3)]};
          if (mem_we_o) begin
            mem[mem_addr_o[7:0]]          <= mem_wdata_o[31:24];
            mem[8'(mem_addr_o[7:0]+1)] <= mem_wdata_o[23:16];
            mem[8'(mem_addr_o[7:0]+2)] <= mem_wdata_o[15:8];
            mem[8'(mem_addr_o[7:0]+3)] <= mem_wdata_o[7:0];
          end
        end else begin
          n_byte++;
          mem_rdata_i <= {24'h0, mem[mem_addr_o[7:0]]};
          if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o[7:0];
        end
      end
    end
  end

  // Register file, stability and done-timing monitors.
  always @(posedge clk) begin
    cyc++;
    if (rf_we_o) begin
      rf[rf_waddr_o] <= rf_wdata_o;
      n_we++;
    end
    if (p_req && !p_ack && (!mem_req_o || mem_addr_o != p_addr)) stab_err++;
    if (done_o) begin
      n_done++;
      if (cyc - last_evt != 1) gap_err++;
    end
    if ((mem_req_o && mem_ack_i) || rf_we_o || (start_i && !busy_o)) last_evt = cyc;
    p_req  = mem_req_o;
    p_ack  = mem_ack_i;
    p_addr = mem_addr_o;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic init_state();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 32; i++)
      rf[i] = {8'(i*3+1), 8'(i*5+2), 8'(i*7+3), 8'(i*11+4)};
    n_word = 0; n_byte = 0; n_we = 0; n_done = 0;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while (!done_o && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done_o == 1'b1, {tag, " done seen"}, 32'(done_o), 1);
    @(negedge clk);
    check(done_o == 1'b0, "R11 done one cycle", 32'(done_o), 0);
  endtask

  task automatic run(input bit st, input bit rv, input bit mu, input int idx,
                     input int a, input int cnt, input string tag);
    @(negedge clk);
    start_i = 1'b1; store_i = st; rev_i = rv; multi_i = mu;
    reg_idx_i = 5'(idx); addr_i = 32'(a); count_i = 8'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    wait_done(tag);
  endtask

  task automatic t_reset();
    check(!mem_req_o && !rf_we_o && !done_o && !busy_o, "R12 reset idle",
          {28'h0, mem_req_o, rf_we_o, done_o, busy_o}, 0);
  endtask

  task automatic t_be_load();
    logic [31:0] e3, e4, e5, e6;
    init_state(); lat_cfg = 1;
    e3 = mword(8'h10); e4 = mword(8'h14); e5 = {mem[8'h18], mem[8'h19], 16'h0}; e6 = rf[6];
    run(0, 0, 0, 3, 8'h10, 10, "R1 be load");
    check(rf[3] == e3, "R1 be word0", rf[3], e3);
    check(rf[4] == e4, "R2 be word1 next reg", rf[4], e4);
    check(rf[5] == e5, "R4 be tail zero fill", rf[5], e5);
    check(rf[6] == e6, "R4 no extra reg", rf[6], e6);
    check(n_word == 2 && n_byte == 2, "R3 access mix", 32'(n_word*16+n_byte), 32'h22);
  endtask

  task automatic t_wrap();
    logic [31:0] e30, e31, e0, e1;
    init_state(); lat_cfg = 0;
    e30 = mword(8'h20); e31 = mword(8'h24); e0 = mword(8'h28); e1 = rf[1];
    run(0, 0, 0, 30, 8'h20, 12, "R2 wrap");
    check(rf[30] == e30 && rf[31] == e31, "R2 top regs", rf[31], e31);
    check(rf[0] == e0, "R2 wrap to 0", rf[0], e0);
    check(rf[1] == e1 && n_byte == 0, "R9 no tail", rf[1], e1);
  endtask

  task automatic t_rev_load();
    logic [31:0] e7, e8;
    init_state(); lat_cfg = 2;
    e7 = bswap(mword(8'h31));
    e8 = {8'h0, mem[8'h37], mem[8'h36], mem[8'h35]};
    run(0, 1, 0, 7, 8'h31, 7, "R5 rev load");
    check(rf[7] == e7, "R5 rev word swap", rf[7], e7);
    check(rf[8] == e8, "R6 rev tail", rf[8], e8);
  endtask

  task automatic t_be_store();
    logic [31:0] r2, r3;
    logic [7:0]  keep;
    init_state(); lat_cfg = 1;
    r2 = rf[2]; r3 = rf[3]; keep = mem[8'h46];
    run(1, 0, 0, 2, 8'h40, 6, "R7 be store");
    check(mword(8'h40) == r2, "R1 be store word", mword(8'h40), r2);
    check({mem[8'h44], mem[8'h45]} == r3[31:16], "R7 be store tail",
          {16'h0, mem[8'h44], mem[8'h45]}, {16'h0, r3[31:16]});
    check(mem[8'h46] == keep && n_we == 0, "R7 store bounds no rf write",
          {24'h0, mem[8'h46]}, {24'h0, keep});
  endtask

  task automatic t_rev_store();
    logic [31:0] r9, r10;
    logic [7:0]  keep;
    init_state(); lat_cfg = 0;
    r9 = rf[9]; r10 = rf[10]; keep = mem[8'h57];
    run(1, 1, 0, 9, 8'h50, 7, "R5 rev store");
    check(mword(8'h50) == bswap(r9), "R5 rev store word", mword(8'h50), bswap(r9));
    check({mem[8'h54], mem[8'h55], mem[8'h56]} == {r10[7:0], r10[15:8], r10[23:16]},
          "R7 rev store tail", {8'h0, mem[8'h54], mem[8'h55], mem[8'h56]},
          {8'h0, r10[7:0], r10[15:8], r10[23:16]});
    check(mem[8'h57] == keep, "R3 rev store stops", {24'h0, mem[8'h57]}, {24'h0, keep});
  endtask

  task automatic t_multi();
    logic [31:0] e28, e31, e0;
    init_state(); lat_cfg = 1;
    e28 = mword(8'h60); e31 = mword(8'h6C); e0 = rf[0];
    run(0, 0, 1, 28, 8'h60, 3, "R8 multi");
    check(rf[28] == e28 && rf[31] == e31, "R8 multi regs", rf[31], e31);
    check(rf[0] == e0, "R8 multi no wrap", rf[0], e0);
    check(n_word == 4 && n_byte == 0, "R8 count ignored", 32'(n_word*16+n_byte), 32'h40);
  endtask

  task automatic t_zero();
    logic [31:0] e14;
    init_state(); lat_cfg = 0;
    run(0, 0, 0, 5, 8'h70, 0, "R9 zero");
    check(n_word == 0 && n_byte == 0 && n_we == 0, "R9 zero count no access",
          32'(n_word + n_byte + n_we), 0);
    init_state();
    e14 = rf[14];
    run(0, 0, 0, 12, 8'h70, 8, "R9 exact words");
    check(n_byte == 0 && n_we == 2 && rf[14] == e14, "R9 no tail write", rf[14], e14);
  endtask

  task automatic t_busy_start();
    logic [31:0] e20, e21, e5;
    init_state(); lat_cfg = 2;
    e20 = mword(8'h80); e21 = mword(8'h84); e5 = rf[5];
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b0; rev_i = 1'b0; multi_i = 1'b0;
    reg_idx_i = 5'd20; addr_i = 32'h80; count_i = 8'd8;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; reg_idx_i = 5'd5; addr_i = 32'hA0; count_i = 8'd4;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R11 busy start");
    repeat (4) @(negedge clk);
    check(rf[20] == e20 && rf[21] == e21, "R11 first run intact", rf[21], e21);
    check(rf[5] == e5 && n_done == 1, "R11 second start ignored", rf[5], e5);
  endtask

  initial begin
    init_state();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_be_load();
    t_wrap();
    t_rev_load();
    t_be_store();
    t_rev_store();
    t_multi();
    t_zero();
    t_busy_start();
    check(stab_err == 0, "R10 request held until ack", 32'(stab_err), 0);
    check(gap_err == 0, "R11 done one cycle after last event", 32'(gap_err), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog: a hung run is counted as a failure and still summarised.
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule